// File: doc/BRIEF.md
# Flash Status Pin Mode Controller

This block produces the active-low status output of a flash memory controller. Software selects one of four reporting modes with a two-write configuration sequence on a simple write strobe and data bus. In the default mode the output is a ready/busy level that follows the internal write state machine. In the other three modes the output rests high and drops for a fixed time when a chosen kind of operation finishes: erase only, program only, or either one.

The fixed low time is set by parameters: a clock frequency and a pulse length in nanoseconds. From these the block derives a cycle count, rounded up. The block takes in the busy flag and single-cycle completion strobes, each tagged as erase or program. It holds a two-bit mode and a down-counter.

Top module: `flash_status_pin_ctrl`

## Requirements
- R1: After reset the mode is the level mode (code 00), so `status_n` equals the inverse of `busy` before any configuration write.
- R2: A write of 0xB8 followed by a later write of a configuration byte sets the mode to bits 1:0 of that byte. The new mode governs `status_n` from the clock after the configuration byte's write edge.
- R3: Bits 7:2 of the configuration byte are ignored. For example, 0xB8 then 0xFE selects code 10.
- R4: In level mode (00) `status_n` is low while `busy` is high and high while `busy` is low.
- R5: Code 01 pulses `status_n` on `done_erase` only. A `done_prog` strobe produces no pulse.
- R6: Code 10 pulses `status_n` on `done_prog` only. A `done_erase` strobe produces no pulse.
- R7: Code 11 pulses `status_n` on either `done_erase` or `done_prog`.
- R8: A pulse keeps `status_n` low for exactly PULSE_CYC cycles, starting the cycle after the strobe's clock edge. PULSE_CYC is ceil(CLK_FREQ_HZ × PULSE_NS / 1e9), which gives 25 at 100 MHz and 250 ns.
- R9: In any pulse mode `busy` has no effect, and `status_n` is high when no pulse is running.
- R10: A qualifying completion strobe during a running pulse restarts the count. The low time then extends to PULSE_CYC cycles after the new strobe.
- R11: If the write after 0xB8 is 0xB8 again, the sequence is aborted and the mode is unchanged. The next write is then treated as a first write again.
- R12: A pulse already running when the mode changes runs to its full length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_data | input | 8 | Bus write data |
| busy | input | 1 | Write state machine busy flag |
| done_erase | input | 1 | Single-cycle strobe: an erase (or erase queue) finished |
| done_prog | input | 1 | Single-cycle strobe: a program operation finished |
| status_n | output | 1 | Active-low status output |

## Verification
A wrong mode register shows up at the port on the first cycle after the configuration edge. In level mode the output stops tracking `busy`. In pulse modes a strobe of the wrong type yields a pulse, or a strobe of the right type yields none. A wrong pulse counter shows as a low time other than 25 cycles, either on a single strobe or on a restarted one. The abort path and the rule that a running pulse finishes are checked by timing the low window across writes that are issued while the pulse runs.

// File: rtl/flash_sts_pkg.sv
package flash_sts_pkg;
   typedef enum logic [1:0] {
      MODE_LEVEL = 2'b00,
      MODE_ERASE = 2'b01,
      MODE_PROG  = 2'b10,
      MODE_BOTH  = 2'b11
   } sts_mode_e;

   localparam int unsigned MODE_W = 2;
endpackage

// File: rtl/sts_cfg_decoder.sv
module sts_cfg_decoder
   import flash_sts_pkg::*;
#(
   parameter int unsigned DATA_W   = 8,
   parameter logic [7:0]  CMD_BYTE = 8'hB8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output sts_mode_e         mode_o
);
   logic      armed_q;
   sts_mode_e mode_q;
   logic      is_cmd;

   generate
      if (DATA_W > 8) begin : g_wide
         assign is_cmd = (wr_data[7:0] == CMD_BYTE) && (wr_data[DATA_W-1:8] == '0);
      end else begin : g_byte
         assign is_cmd = (wr_data == CMD_BYTE[DATA_W-1:0]);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         mode_q  <= MODE_LEVEL;
      end else if (wr_en) begin
         if (!armed_q) begin
            armed_q <= is_cmd;
         end else begin
            armed_q <= 1'b0;
            if (!is_cmd) begin
               mode_q <= sts_mode_e'(wr_data[MODE_W-1:0]);
            end
         end
      end
   end

   assign mode_o = mode_q;
endmodule

// File: rtl/sts_pulse_timer.sv
module sts_pulse_timer #(
   parameter int unsigned PULSE_CYC = 25,
   parameter int unsigned CNT_W     = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             trig,
   output logic [CNT_W-1:0] cnt_o,
   output logic             active_o
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (trig) begin
         cnt_q <= CNT_W'(PULSE_CYC);
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   assign cnt_o    = cnt_q;
   assign active_o = (cnt_q != '0);
endmodule

// File: rtl/flash_status_pin_ctrl.sv
module flash_status_pin_ctrl
   import flash_sts_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter logic [7:0]  CMD_BYTE    = 8'hB8,
   parameter int unsigned CLK_FREQ_HZ = 100_000_000,
   parameter int unsigned PULSE_NS    = 250
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              busy,
   input  logic              done_erase,
   input  logic              done_prog,
   output logic              status_n
);
   localparam longint unsigned PROD      = 64'(CLK_FREQ_HZ) * 64'(PULSE_NS);
   localparam longint unsigned NS_PER_S  = 64'd1_000_000_000;
   localparam int unsigned     PULSE_CYC = int'((PROD + NS_PER_S - 64'd1) / NS_PER_S);
   localparam int unsigned     CNT_W     = $clog2(PULSE_CYC + 1);

   generate
      if (DATA_W < MODE_W) begin : g_bad_width
         $error("DATA_W must hold the mode field");
      end
      if (PULSE_CYC < 1) begin : g_bad_pulse
         $error("pulse length rounds to zero cycles");
      end
   endgenerate

   sts_mode_e        mode_q;
   logic [CNT_W-1:0] cnt_q;
   logic             pulse_on;
   logic             trig;

   sts_cfg_decoder #(
      .DATA_W   (DATA_W),
      .CMD_BYTE (CMD_BYTE)
   ) u_dec (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .mode_o  (mode_q)
   );

   // bit 0 of the mode enables erase reporting, bit 1 program reporting
   assign trig = (done_erase & mode_q[0]) | (done_prog & mode_q[1]);

   sts_pulse_timer #(
      .PULSE_CYC (PULSE_CYC),
      .CNT_W     (CNT_W)
   ) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .trig     (trig),
      .cnt_o    (cnt_q),
      .active_o (pulse_on)
   );

   assign status_n = ~(pulse_on | ((mode_q == MODE_LEVEL) & busy));
endmodule

// File: rtl/flash_status_pin_chk.sv
module flash_status_pin_chk #(
   parameter int unsigned PULSE_CYC = 25,
   parameter int unsigned CNT_W     = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic             busy,
   input logic             done_erase,
   input logic             done_prog,
   input logic             status_n,
   input logic [1:0]       mode,
   input logic [CNT_W-1:0] cnt
);
   // R1
   reset_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (mode == 2'b00));

   // R2
   mode_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mode) |-> $past(wr_en));

   // R4
   level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b00 && cnt == '0) |-> (status_n == !busy));

   // R8
   pulse_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((done_erase && mode[0]) || (done_prog && mode[1])) |=> (cnt == CNT_W'(PULSE_CYC)));

   // R8
   pulse_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != '0) |-> !status_n);

   // R9
   idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != 2'b00 && cnt == '0) |-> status_n);
endmodule

bind flash_status_pin_ctrl flash_status_pin_chk #(
   .PULSE_CYC (PULSE_CYC),
   .CNT_W     (CNT_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .busy       (busy),
   .done_erase (done_erase),
   .done_prog  (done_prog),
   .status_n   (status_n),
   .mode       (mode_q),
   .cnt        (cnt_q)
);

// File: tb/flash_status_pin_ctrl_bench.sv
module flash_status_pin_ctrl_bench;
   localparam time CLK_PERIOD = 10ns;
   localparam int  PULSE_EXP  = 25;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       busy = 1'b0;
   logic       done_erase = 1'b0;
   logic       done_prog = 1'b0;
   logic       status_n;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   flash_status_pin_ctrl u_flash_status_pin_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_data    (wr_data),
      .busy       (busy),
      .done_erase (done_erase),
      .done_prog  (done_prog),
      .status_n   (status_n)
   );

   // {wr_en, wr_data, busy, done_erase, done_prog, expected status_n}
   // expected value is sampled after the inputs are applied, before the edge
   localparam logic [12:0] VEC [10] = '{
      {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0}, // R4 busy -> low
      {1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1}, // R4 idle -> high
      {1'b1, 8'hB8, 1'b1, 1'b0, 1'b0, 1'b0}, // R2 command byte, still level
      {1'b1, 8'h01, 1'b1, 1'b0, 1'b0, 1'b0}, // R2 config byte, mode not yet active
      {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1}, // R9 busy ignored in erase mode
      {1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1}, // R5 program strobe
      {1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1}, // R5 no pulse from program
      {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1}, // R5 erase strobe
      {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0}, // R5 erase pulse low
      {1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0}  // R8 pulse still running
   };

   task automatic check(input string req, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: status_n=%b expected %b", req, act, exp);
      end
   endtask

   task automatic check_int(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic write_byte(input logic [7:0] b);
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = b;
      @(negedge clk);
      wr_en = 1'b0;
      wr_data = 8'h00;
   endtask

   task automatic configure(input logic [7:0] b);
      write_byte(8'hB8);
      write_byte(b);
   endtask

   // strobe one completion event and count the low cycles that follow
   task automatic fire_and_count(input logic er, input logic pr, output int lows);
      @(negedge clk);
      done_erase = er;
      done_prog = pr;
      @(negedge clk);
      done_erase = 1'b0;
      done_prog = 1'b0;
      lows = 0;
      #1;
      while (status_n == 1'b0 && lows < 100) begin
         lows++;
         @(negedge clk);
         #1;
      end
   endtask

   initial begin
      int lows;
      busy = 1'b1;
      #(CLK_PERIOD * 2);
      check("R1", status_n, 1'b0);
      busy = 1'b0;
      #1;
      check("R1", status_n, 1'b1);
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         {wr_en, wr_data, busy, done_erase, done_prog} = VEC[i][12:1];
         #1;
         check($sformatf("R2/R4/R5/R8/R9 vec%0d", i), status_n, VEC[i][0]);
      end
      @(negedge clk);
      {wr_en, wr_data, busy, done_erase, done_prog} = '0;
      repeat (30) @(negedge clk);

      // R8 exact width in erase mode
      fire_and_count(1'b1, 1'b0, lows);
      check_int("R8 pulse width", lows, PULSE_EXP);

      // R3 reserved bits ignored: FE selects program mode
      configure(8'hFE);
      fire_and_count(1'b1, 1'b0, lows);
      check_int("R3/R6 erase ignored in program mode", lows, 0);
      fire_and_count(1'b0, 1'b1, lows);
      check_int("R6 program pulse", lows, PULSE_EXP);

      // R7 both
      configure(8'h03);
      fire_and_count(1'b1, 1'b0, lows);
      check_int("R7 erase pulse", lows, PULSE_EXP);
      fire_and_count(1'b0, 1'b1, lows);
      check_int("R7 program pulse", lows, PULSE_EXP);

      // R10 restart: second strobe 10 cycles after the first
      lows = 0;
      for (int i = 0; i < 60; i++) begin
         @(negedge clk);
         done_prog = (i == 0);
         done_erase = (i == 10);
         #1;
         if (status_n == 1'b0) lows++;
      end
      done_prog = 1'b0;
      done_erase = 1'b0;
      check_int("R10 restarted pulse", lows, 35);

      // R12 mode change to level during a pulse, pulse finishes
      busy = 1'b0;
      lows = 0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         done_erase = (i == 0);
         wr_en = (i == 2) || (i == 4);
         wr_data = (i == 2) ? 8'hB8 : 8'h00;
         #1;
         if (status_n == 1'b0) lows++;
      end
      done_erase = 1'b0;
      wr_en = 1'b0;
      check_int("R12 pulse completes across mode change", lows, PULSE_EXP);
      busy = 1'b1;
      #1;
      check("R12 now level mode", status_n, 1'b0);
      busy = 1'b0;

      // R11 abort: B8, B8, 01 leaves level mode in place
      write_byte(8'hB8);
      write_byte(8'hB8);
      write_byte(8'h01);
      busy = 1'b1;
      #1;
      check("R11 abort keeps level mode", status_n, 1'b0);
      busy = 1'b0;
      fire_and_count(1'b1, 1'b0, lows);
      check_int("R11 no pulse after abort", lows, 0);

      // R9 busy ignored while idle in pulse mode
      configure(8'h02);
      busy = 1'b1;
      #1;
      check("R9 busy ignored", status_n, 1'b1);
      busy = 1'b0;

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog: run hung, expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule